// File: doc/BRIEF.md
# Synchronous FIFO with Same-Cycle Pass-Through

This block is a single-clock FIFO with a valid/ready handshake on each side. A producer offers words on the write side. A consumer takes them in arrival order on the read side. The default depth is two entries, and the depth and the word width are parameters. Read and write pointers each carry a wrap bit beside the slot index. With these bits the block can tell an empty store from a full one when the two indices match. Full, empty and fill-count outputs are derived from the pointers.

A parameter can turn on pass-through. When this is on and the store is empty, a word offered on the write side appears on the read side in the same cycle. If the consumer takes it in that cycle, the word is never written into the store.

For the first cycle after reset is released, a guard flag holds both handshakes inactive. This gives the pointers one clean cycle before any traffic is accepted.

Top module: `sync_fifo_pt`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, empty_o is 1, full_o is 0 and count_o is 0. In that first cycle, rd_valid_o and wr_ready_o are both 0 whatever the inputs are.
- R2: The guard lasts exactly one cycle. From the second cycle after reset onward, wr_ready_o is 1 whenever the FIFO is not full.
- R3: Words leave the read side in the order they were accepted on the write side. rd_data_o shows the oldest stored word whenever rd_valid_o is 1 and the store is nonempty.
- R4: count_o equals the number of stored entries, from 0 to DEPTH. empty_o is 1 exactly when count_o is 0, and full_o is 1 exactly when count_o is DEPTH.
- R5: wr_ready_o is 0 while the FIFO is full. A word offered while full is not stored, and the stored contents and the count are unchanged.
- R6: With PASS=0, rd_valid_o is 1 only when the store holds at least one entry. A word written into an empty FIFO becomes readable in the following cycle.
- R7: With PASS=1 and an empty store, driving wr_valid_i high (outside the guard cycle) gives rd_valid_o=1 and rd_data_o=wr_data_i in the same cycle.
- R8: With PASS=1, if both handshakes complete in a cycle where the store is empty, the word is delivered directly. The count stays 0 and empty_o stays 1.
- R9: Asserting rd_ready_i on an empty FIFO with no write offered has no effect: rd_valid_o is 0 and the count stays 0.
- R10: The default instance has DEPTH=2. In either mode it accepts exactly two words before wr_ready_o drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Producer offers a word |
| wr_ready_o | output | 1 | FIFO can accept a word |
| wr_data_i | input | WIDTH | Word offered by the producer |
| rd_valid_o | output | 1 | A word is available to the consumer |
| rd_ready_i | input | 1 | Consumer takes the word |
| rd_data_o | output | WIDTH | Word presented to the consumer |
| full_o | output | 1 | All DEPTH slots are occupied |
| empty_o | output | 1 | No slot is occupied |
| count_o | output | $clog2(DEPTH+1) | Number of occupied slots |

## Verification
The properties place no protocol demands on the inputs. The producer may drop wr_valid_i before it is accepted, and the consumer may raise rd_ready_i with nothing available. Every property is therefore stated in terms of completed handshakes and port levels alone. The assertions do assume that all inputs are known, stable levels at each rising edge. The stimulus meets this by changing inputs only at falling edges, and random and directed cycles go through the same drive routine. Both a pass-through and a plain instance are driven with identical inputs, so each mode's handling of the empty case is compared against the same traffic.

// File: rtl/fifo_pt_pkg.sv
package fifo_pt_pkg;

  // Slot that follows idx in a ring of depth slots.
  function automatic int unsigned slot_next(int unsigned idx, int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // True when advancing from idx crosses the end of the ring.
  function automatic bit slot_wraps(int unsigned idx, int unsigned depth);
    return (idx + 1 == depth);
  endfunction

  // Occupied slots, given both pointers with their wrap bits.
  function automatic int unsigned fill_level(int unsigned widx, bit wwrap,
                                             int unsigned ridx, bit rwrap,
                                             int unsigned depth);
    int unsigned w = widx + (wwrap ? depth : 0);
    int unsigned r = ridx + (rwrap ? depth : 0);
    return (w + 2 * depth - r) % (2 * depth);
  endfunction

endpackage

// File: rtl/fifo_pt_ptr.sv
module fifo_pt_ptr #(
  parameter int DEPTH = 2,
  parameter int IDXW  = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [IDXW-1:0] idx_o,
  output logic            wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      wrap_o <= 1'b0;
    end else if (adv_i) begin
      idx_o <= IDXW'(fifo_pt_pkg::slot_next(32'(idx_o), DEPTH));
      if (fifo_pt_pkg::slot_wraps(32'(idx_o), DEPTH)) wrap_o <= ~wrap_o;
    end
  end
endmodule

// File: rtl/fifo_pt_mem.sv
module fifo_pt_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2,
  parameter int IDXW  = 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDXW-1:0]  waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IDXW-1:0]  raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == IDXW'(e))) slot_q[e] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/fifo_pt_guard.sv
module fifo_pt_guard (
  input  logic clk_i,
  input  logic rst_ni,
  output logic guard_o
);
  // Set through reset, cleared by the first edge after release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) guard_o <= 1'b1;
    else         guard_o <= 1'b0;
  end
endmodule

// File: rtl/sync_fifo_pt.sv
module sync_fifo_pt #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2,
  parameter bit PASS  = 1'b1,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic            guard;
  logic [IDXW-1:0] widx, ridx;
  logic            wwrap, rwrap;
  logic            store_empty, store_full;
  logic            wr_fire, rd_fire, bypass, push, pop;
  logic [WIDTH-1:0] mem_rdata;

  fifo_pt_guard u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .guard_o (guard)
  );

  fifo_pt_ptr #(.DEPTH(DEPTH), .IDXW(IDXW)) u_wptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (push),
    .idx_o  (widx),
    .wrap_o (wwrap)
  );

  fifo_pt_ptr #(.DEPTH(DEPTH), .IDXW(IDXW)) u_rptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (pop),
    .idx_o  (ridx),
    .wrap_o (rwrap)
  );

  fifo_pt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .IDXW(IDXW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (widx),
    .wdata_i (wr_data_i),
    .raddr_i (ridx),
    .rdata_o (mem_rdata)
  );

  assign store_empty = (widx == ridx) && (wwrap == rwrap);
  assign store_full  = (widx == ridx) && (wwrap != rwrap);

  assign wr_ready_o = !guard && !store_full;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign rd_fire    = rd_valid_o && rd_ready_i;

  if (PASS) begin : g_pass
    assign rd_valid_o = !guard && (!store_empty || wr_valid_i);
    assign rd_data_o  = store_empty ? wr_data_i : mem_rdata;
    assign bypass     = store_empty && wr_fire && rd_fire;
  end else begin : g_plain
    assign rd_valid_o = !guard && !store_empty;
    assign rd_data_o  = mem_rdata;
    assign bypass     = 1'b0;
  end

  assign push = wr_fire && !bypass;
  assign pop  = rd_fire && !bypass;

  assign full_o  = store_full;
  assign empty_o = store_empty;
  assign count_o = CW'(fifo_pt_pkg::fill_level(32'(widx), wwrap, 32'(ridx), rwrap, DEPTH));
endmodule

// File: rtl/fifo_pt_chk.sv
module fifo_pt_chk #(
  parameter int DEPTH = 2,
  parameter int CW    = 2,
  parameter bit PASS  = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          guard,
  input logic          wr_valid_i,
  input logic          wr_ready_o,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic          full_o,
  input logic          empty_o,
  input logic [CW-1:0] count_o,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          bypass
);
  a_r1_guard_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard |-> (!rd_valid_o && !wr_ready_o));

  a_r2_guard_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard |=> !guard);

  a_r2_guard_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !guard |=> !guard);

  a_r5_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !wr_ready_o);

  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  a_r4_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && !rd_fire) |=> count_o == CW'($past(count_o) + 1'b1));

  a_r4_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && !wr_fire) |=> count_o == CW'($past(count_o) - 1'b1));

  a_r8_bypass_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> (count_o == $past(count_o)) && empty_o);

  a_r6_plain_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!PASS && empty_o) |-> !rd_valid_o);

  a_r9_empty_read_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_ready_i && !wr_valid_i) |=> empty_o);
endmodule

bind sync_fifo_pt fifo_pt_chk #(.DEPTH(DEPTH), .CW(CW), .PASS(PASS)) u_fifo_pt_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .guard      (guard),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .count_o    (count_o),
  .wr_fire    (wr_fire),
  .rd_fire    (rd_fire),
  .bypass     (bypass)
);

// File: tb/test_sync_fifo_pt.sv
module test_sync_fifo_pt;
  localparam int W  = 8;
  localparam int D  = 2;
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         wv, rr;
  logic [W-1:0] wd;
  logic         rvalid [2];
  logic         wready [2];
  logic         full   [2];
  logic         empty  [2];
  logic [W-1:0] rdata  [2];
  logic [CW-1:0] cnt   [2];

  // Index 0: pass-through instance, index 1: plain instance.
  sync_fifo_pt #(.WIDTH(W), .DEPTH(D), .PASS(1'b1)) i_sync_fifo_pt (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_ready_o(wready[0]),
    .wr_data_i(wd), .rd_valid_o(rvalid[0]), .rd_ready_i(rr), .rd_data_o(rdata[0]),
    .full_o(full[0]), .empty_o(empty[0]), .count_o(cnt[0]));

  sync_fifo_pt #(.WIDTH(W), .DEPTH(D), .PASS(1'b0)) i_sync_fifo_pt_np (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wv), .wr_ready_o(wready[1]),
    .wr_data_i(wd), .rd_valid_o(rvalid[1]), .rd_ready_i(rr), .rd_data_o(rdata[1]),
    .full_o(full[1]), .empty_o(empty[1]), .count_o(cnt[1]));

  int errs = 0;
  int checks = 0;

  logic [W-1:0] mq [2][D];
  int           mhead [2];
  int           mcnt  [2];
  bit           mguard;

  function automatic bit e_rvalid(int k);
    return !mguard && (mcnt[k] != 0 || (k == 0 && wv));
  endfunction

  function automatic bit e_wready(int k);
    return !mguard && (mcnt[k] != D);
  endfunction

  function automatic logic [W-1:0] e_rdata(int k);
    return (mcnt[k] == 0) ? wd : mq[k][mhead[k]];
  endfunction

  task automatic chk(string req, string what, int k, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s inst%0d: actual=%0d expected=%0d", req, what, k, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      mhead[k] = 0;
      mcnt[k]  = 0;
    end
    mguard = 1'b1;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(bit v, logic [W-1:0] d, bit r, string req);
    bit wf [2];
    bit rf [2];
    wv = v; wd = d; rr = r;
    #1;
    for (int k = 0; k < 2; k++) begin
      chk(req, "wr_ready", k, int'(wready[k]), int'(e_wready(k)));
      chk(req, "rd_valid", k, int'(rvalid[k]), int'(e_rvalid(k)));
      chk(req, "count",    k, int'(cnt[k]),    mcnt[k]);
      chk(req, "full",     k, int'(full[k]),   int'(mcnt[k] == D));
      chk(req, "empty",    k, int'(empty[k]),  int'(mcnt[k] == 0));
      if (e_rvalid(k)) chk(req, "rd_data", k, int'(rdata[k]), int'(e_rdata(k)));
      wf[k] = v && e_wready(k);
      rf[k] = r && e_rvalid(k);
    end
    @(posedge clk);
    mguard = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (!(k == 0 && mcnt[k] == 0 && wf[k] && rf[k])) begin
        int tail = (mhead[k] + mcnt[k]) % D;
        if (rf[k]) begin
          mhead[k] = (mhead[k] + 1) % D;
          mcnt[k]--;
        end
        if (wf[k]) begin
          mq[k][tail] = d;
          mcnt[k]++;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wv = 1'b0; rr = 1'b0; wd = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      chk("R1", "reset empty", k, int'(empty[k]), 1);
      chk("R1", "reset full",  k, int'(full[k]),  0);
      chk("R1", "reset count", k, int'(cnt[k]),   0);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    errs++;
    checks++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd12345;
    void'($urandom(seed));

    do_reset();
    // Guard cycle: both handshakes held off despite offers (R1).
    step(1'b1, 8'hAA, 1'b1, "R1");
    // Guard released, empty: ready again (R2).
    step(1'b0, 8'h00, 1'b0, "R2");
    // Read on an empty FIFO with no write (R9).
    step(1'b0, 8'h00, 1'b1, "R9");
    step(1'b0, 8'h00, 1'b0, "R9");
    // Simultaneous write and read on empty: pass-through delivers directly (R8, R7).
    step(1'b1, 8'h11, 1'b1, "R8");
    // Plain instance now holds one word and shows it one cycle later (R6).
    step(1'b0, 8'h00, 1'b0, "R6");
    step(1'b0, 8'h00, 1'b1, "R6");
    // Write without read on empty: visible at once in pass-through mode (R7).
    step(1'b1, 8'h22, 1'b0, "R7");
    // Fill to depth two (R10, R4).
    step(1'b1, 8'h33, 1'b0, "R10");
    // Full: write offered and refused (R5).
    step(1'b1, 8'h44, 1'b0, "R5");
    step(1'b0, 8'h00, 1'b0, "R5");
    // Drain in order (R3).
    step(1'b0, 8'h00, 1'b1, "R3");
    step(1'b0, 8'h00, 1'b1, "R3");
    step(1'b0, 8'h00, 1'b1, "R4");

    // Constrained random traffic (R3, R4).
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 100) < 60;
      bit r = ($urandom % 100) < 55;
      step(v, W'($urandom), r, "R3");
    end

    // Reset again with offers pending (R1, R2).
    do_reset();
    step(1'b1, 8'h5A, 1'b1, "R1");
    step(1'b1, 8'h5B, 1'b0, "R2");
    step(1'b1, 8'h5C, 1'b0, "R10");
    step(1'b1, 8'h5D, 1'b1, "R5");
    step(1'b0, 8'h00, 1'b1, "R3");
    step(1'b0, 8'h00, 1'b1, "R3");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule